// File: doc/BRIEF.md
# Bus Condition and General-Call Detector

This block watches the clock and data lines of a two-wire serial bus from the target side. Both lines are brought into the system clock domain through a synchroniser chain and then compared with their previous sampled values. The comparison finds start conditions, repeated starts and stop conditions. Each one is reported as a single-cycle pulse, and a separate pulse flags any condition that arrives at a point in a transfer where it is not allowed.

After every start, the block shifts in the first byte, most significant bit first, taking one bit on each rising edge of the clock line. When that byte is all zeros, a sticky general-call flag is raised, but only if the block is acting as a target and general-call recognition is enabled. Any start, repeated start or stop clears the flag, whether or not the condition was legal.

A registered copy of the synchronised data line is also provided for recovery firmware. Driving the enable input low holds every flag, pulse and counter at zero.

Top module: `bus_cond_gc_detect`

## Requirements
- R1: A falling data line while the clock line is high gives exactly one cycle of `start_pulse`. A rising data line while the clock line is high gives exactly one cycle of `stop_pulse`. Each pulse appears on the third rising system-clock edge after the line change.
- R2: After a start, the first eight clock-line rising edges shift in the address byte, most significant bit first. When that byte equals 00h, `gc_flag` is set by the third system-clock edge after the eighth rise, provided `tgt_mode`=1 and `gc_en`=1 at that time. The flag then stays set.
- R3: `gc_flag` stays 0 if the address byte is non-zero, if `gc_en`=0, or if `tgt_mode`=0.
- R4: Only the address byte is compared. A zero byte that follows a non-zero address, inside the same transfer, leaves `gc_flag` at 0.
- R5: A start or a repeated start clears `gc_flag`, and this includes a start that is illegal.
- R6: A stop clears `gc_flag`.
- R7: `illegal_pulse` goes high in the same cycle as the condition pulse in two cases: a start or stop arrives after 1 to 7 completed bits of a byte, or a stop arrives while the address phase is still open. The address phase runs from the start up to the ninth clock-line fall, which ends the acknowledge bit. A stop after the acknowledge of the address byte gives no `illegal_pulse`.
- R8: `sda_level` follows the synchronised data line three system-clock edges after the line changes, including while `en`=0. It leaves reset at 1.
- R9: While `en`=0, `gc_flag` and all three pulses are 0 from the first system-clock edge on, and bus activity has no effect. After `en` returns to 1, the block waits for a new start.
- R10: After a synchronous reset with both lines high, all pulses and `gc_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable; 0 clears and holds all state |
| tgt_mode | input | 1 | 1 while the block acts as a bus target |
| gc_en | input | 1 | General-call recognition enable |
| scl_in | input | 1 | Raw clock line from the pad |
| sda_in | input | 1 | Raw data line from the pad |
| start_pulse | output | 1 | One-cycle pulse per start or repeated start |
| stop_pulse | output | 1 | One-cycle pulse per stop |
| illegal_pulse | output | 1 | One-cycle pulse for a misplaced start or stop |
| gc_flag | output | 1 | Sticky general-call match flag |
| sda_level | output | 1 | Registered view of the synchronised data line |

## Verification
A change on either bus line takes three system-clock edges to reach the outputs: two synchroniser stages, then one output register. The bench therefore drives the lines on a falling edge and samples on the falling edge that follows the third rising edge. One more falling edge later it confirms that every pulse has returned low. The `en` input is not synchronised, so its effect is checked one edge after it changes. The general-call flag is sticky, so it is read once the whole byte has been clocked in.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
    logic sda;
  } bus_evt_t;
endpackage

// File: rtl/bcd_sync.sv
module bcd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{IDLE[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[LAST];
  end
endmodule

// File: rtl/bcd_cond.sv
module bcd_cond
  import bcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt,
  output logic     sda_view
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
      sda_view <= 1'b1;
    end else begin
      scl_p    <= scl_s;
      sda_p    <= sda_s;
      sda_view <= sda_s;
    end
  end

  always_comb begin
    evt.start    = scl_s & scl_p & sda_p & ~sda_s;
    evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
    evt.scl_rise = scl_s & ~scl_p;
    evt.scl_fall = ~scl_s & scl_p;
    evt.sda      = sda_s;
  end

  a_r1_one_condition: assert property (@(posedge clk) disable iff (rst)
    !(evt.start && evt.stop));
  a_r1_start_needs_high_clock: assert property (@(posedge clk) disable iff (rst)
    evt.start |-> (scl_s && scl_p));
endmodule

// File: rtl/bcd_track.sv
module bcd_track
  import bcd_pkg::*;
#(
  parameter int BITS = 8,
  parameter logic [BITS-1:0] GC_ADDR = '0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     tgt_mode,
  input  logic     gc_en,
  input  bus_evt_t evt,
  output logic     start_q,
  output logic     stop_q,
  output logic     illegal_q,
  output logic     gc_q
);
  localparam int CW = $clog2(BITS + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(BITS - 1);
  localparam logic [CW-1:0] ACK_POS  = CW'(BITS);

  logic            busy, in_addr, hi_seen;
  logic [CW-1:0]   cnt;
  logic [BITS-1:0] shreg;
  logic [BITS-1:0] next_byte;
  logic            mid_byte, bad;

  assign next_byte = {shreg[BITS-2:0], evt.sda};
  assign mid_byte  = (cnt != '0) && (cnt < ACK_POS);
  assign bad       = ((evt.start || evt.stop) && mid_byte) || (evt.stop && in_addr);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      start_q <= 1'b0; stop_q <= 1'b0; illegal_q <= 1'b0; gc_q <= 1'b0;
      busy <= 1'b0; in_addr <= 1'b0; hi_seen <= 1'b0;
      cnt <= '0; shreg <= '0;
    end else begin
      start_q   <= evt.start;
      stop_q    <= evt.stop;
      illegal_q <= bad;
      if (evt.start) begin
        busy <= 1'b1; in_addr <= 1'b1; hi_seen <= 1'b0;
        cnt <= '0; shreg <= '0; gc_q <= 1'b0;
      end else if (evt.stop) begin
        busy <= 1'b0; in_addr <= 1'b0; hi_seen <= 1'b0;
        cnt <= '0; gc_q <= 1'b0;
      end else if (busy && evt.scl_rise) begin
        hi_seen <= 1'b1;
        if (cnt < ACK_POS) shreg <= next_byte;
        if (in_addr && cnt == LAST_BIT && next_byte == GC_ADDR && tgt_mode && gc_en)
          gc_q <= 1'b1;
      end else if (busy && evt.scl_fall && hi_seen) begin
        hi_seen <= 1'b0;
        if (cnt == ACK_POS) begin
          cnt <= '0; in_addr <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r2_gc_needs_qual: assert property (@(posedge clk) disable iff (rst)
    $rose(gc_q) |-> $past(tgt_mode && gc_en && en));
  a_r5_start_clears: assert property (@(posedge clk) disable iff (rst)
    evt.start |=> !gc_q);
  a_r6_stop_clears: assert property (@(posedge clk) disable iff (rst)
    evt.stop |=> !gc_q);
  a_r7_illegal_with_cond: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> (start_q || stop_q));
  a_r9_disable_holds: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!gc_q && !illegal_q && !start_q && !stop_q));
  a_r1_pulse_single: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
endmodule

// File: rtl/bus_cond_gc_detect.sv
module bus_cond_gc_detect
  import bcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BITS   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tgt_mode,
  input  logic gc_en,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_pulse,
  output logic stop_pulse,
  output logic illegal_pulse,
  output logic gc_flag,
  output logic sda_level
);
  localparam logic [ADDR_BITS-1:0] GC_CODE = '0;

  logic [1:0] lines_s;
  bus_evt_t   evt;

  bcd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(lines_s)
  );

  bcd_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .evt(evt), .sda_view(sda_level)
  );

  bcd_track #(.BITS(ADDR_BITS), .GC_ADDR(GC_CODE)) u_track (
    .clk(clk), .rst(rst), .en(en), .tgt_mode(tgt_mode), .gc_en(gc_en),
    .evt(evt), .start_q(start_pulse), .stop_q(stop_pulse),
    .illegal_q(illegal_pulse), .gc_q(gc_flag)
  );
endmodule

// File: tb/tb_bus_cond_gc_detect.sv
module tb_bus_cond_gc_detect;
  logic clk = 1'b0;
  logic rst, en, tgt_mode, gc_en, scl, sda;
  logic start_pulse, stop_pulse, illegal_pulse, gc_flag, sda_level;
  int   n_chk = 0, n_fail = 0;
  logic s_st, s_sp, s_il, wide;

  always #2 clk = ~clk;

  bus_cond_gc_detect dut (
    .clk(clk), .rst(rst), .en(en), .tgt_mode(tgt_mode), .gc_en(gc_en),
    .scl_in(scl), .sda_in(sda), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .illegal_pulse(illegal_pulse), .gc_flag(gc_flag), .sda_level(sda_level)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic d);
    @(negedge clk); scl = c; sda = d;
    repeat (3) @(negedge clk);
    s_st = start_pulse; s_sp = stop_pulse; s_il = illegal_pulse;
    @(negedge clk);
    if (start_pulse || stop_pulse || illegal_pulse) wide = 1'b1;
  endtask

  task automatic do_start();
    step(scl, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0);
  endtask

  task automatic do_stop();
    step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic with_ack);
    for (int i = 7; i >= 0; i--) begin
      step(1'b0, b[i]); step(1'b1, b[i]);
    end
    step(1'b0, b[0]);
    if (with_ack) begin
      step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0);
    end
  endtask

  task automatic t_reset();
    rst = 1; en = 1; tgt_mode = 1; gc_en = 1; scl = 1; sda = 1; wide = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!start_pulse && !stop_pulse && !illegal_pulse, "R10 pulses", int'(start_pulse), 0);
    check(!gc_flag, "R10 gc_flag", int'(gc_flag), 0);
    check(sda_level, "R8 reset level", int'(sda_level), 1);
  endtask

  task automatic t_gc_match();
    do_start();
    check(s_st && !s_sp, "R1 start pulse", int'(s_st), 1);
    check(!s_il, "R7 legal start", int'(s_il), 0);
    send_byte(8'h00, 1'b1);
    check(gc_flag, "R2 gc set", int'(gc_flag), 1);
    send_byte(8'h5A, 1'b1);
    check(gc_flag, "R2 gc sticky", int'(gc_flag), 1);
    do_stop();
    check(s_sp && !s_st, "R1 stop pulse", int'(s_sp), 1);
    check(!s_il, "R7 legal stop after ack", int'(s_il), 0);
    check(!gc_flag, "R6 stop clears", int'(gc_flag), 0);
    check(!wide, "R1 one-cycle pulses", int'(wide), 0);
  endtask

  task automatic t_no_match();
    do_start(); send_byte(8'h80, 1'b1);
    check(!gc_flag, "R3 nonzero address", int'(gc_flag), 0);
    send_byte(8'h00, 1'b1);
    check(!gc_flag, "R4 zero data byte", int'(gc_flag), 0);
    do_stop();
    gc_en = 0; do_start(); send_byte(8'h00, 1'b1);
    check(!gc_flag, "R3 gc_en low", int'(gc_flag), 0);
    do_stop(); gc_en = 1;
    tgt_mode = 0; do_start(); send_byte(8'h00, 1'b1);
    check(!gc_flag, "R3 not target", int'(gc_flag), 0);
    do_stop(); tgt_mode = 1;
    do_start(); send_byte(8'h01, 1'b1);
    check(!gc_flag, "R3 lsb set", int'(gc_flag), 0);
    do_stop();
  endtask

  task automatic t_restart();
    do_start(); send_byte(8'h00, 1'b1);
    check(gc_flag, "R2 gc before restart", int'(gc_flag), 1);
    step(1'b0, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0);
    check(s_st, "R5 restart pulse", int'(s_st), 1);
    check(!s_il, "R7 legal restart", int'(s_il), 0);
    check(!gc_flag, "R5 restart clears", int'(gc_flag), 0);
    do_stop();
  endtask

  task automatic t_illegal();
    do_start(); send_byte(8'h00, 1'b1);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1); step(1'b1, 1'b1);
    end
    step(1'b0, 1'b1); step(1'b1, 1'b1); step(1'b1, 1'b0);
    check(s_st && s_il, "R7 start mid byte", int'(s_il), 1);
    check(!gc_flag, "R5 illegal start clears", int'(gc_flag), 0);
    step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b1);
    check(s_sp && s_il, "R7 stop in address phase", int'(s_il), 1);
    do_start(); send_byte(8'h00, 1'b0);
    do_stop();
    check(s_sp && s_il, "R7 stop before address ack", int'(s_il), 1);
    check(!gc_flag, "R6 illegal stop clears", int'(gc_flag), 0);
  endtask

  task automatic t_sda_view();
    step(1'b0, 1'b0);
    check(!sda_level, "R8 level low", int'(sda_level), 0);
    step(1'b0, 1'b1);
    check(sda_level, "R8 level high", int'(sda_level), 1);
  endtask

  task automatic t_enable();
    step(1'b1, 1'b1);
    do_start(); send_byte(8'h00, 1'b1);
    @(negedge clk); en = 0;
    @(negedge clk);
    check(!gc_flag, "R9 disable clears", int'(gc_flag), 0);
    do_stop(); do_start();
    check(!s_st && !s_il, "R9 no pulse disabled", int'(s_st), 0);
    send_byte(8'h00, 1'b1);
    check(!gc_flag, "R9 no set disabled", int'(gc_flag), 0);
    step(1'b0, 1'b0);
    check(!sda_level, "R8 level while disabled", int'(sda_level), 0);
    en = 1;
    send_byte(8'h00, 1'b1);
    check(!gc_flag, "R9 waits for start", int'(gc_flag), 0);
    do_stop(); do_start(); send_byte(8'h00, 1'b1);
    check(gc_flag, "R9 resumes after start", int'(gc_flag), 1);
    do_stop();
  endtask

  initial begin
    t_reset();
    t_gc_match();
    t_no_match();
    t_restart();
    t_illegal();
    t_sda_view();
    t_enable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule